// File: doc/BRIEF.md
# One-Time-Programmable Fuse Word Burn Controller

This block sits between a register bus and a one-time-programmable fuse array and burns one 32-bit fuse word per request. Software loads a word address and a 16-bit unlock key into the control register, then writes the program data to the data register. That data write is the only thing that starts a burn. The controller then sequences the whole operation by itself. It first reads the word's present fuse contents, which arrive one cycle after the read strobe. It removes every bit that is already blown from the program data. It then steps through bit positions 0 to 31, holding a program strobe for a fixed number of cycles on each position that still needs a fuse blown.

The address used for the burn is copied at the moment the request is accepted. The unlock key is consumed by every request, so each burn needs a fresh key. A per-word lock map, supplied as an input, rejects requests to protected words. A rejected request raises a sticky error flag, and that flag blocks all further requests until software clears it.

Top module: `otp_fuse_prog`

## Requirements
- R1: After reset the control register reads zero, the data register reads zero, busy and error are low, and no fuse read or program strobe is driven.
- R2: A write to offset 0x00 replaces the word address (bits ADDR_W-1:0) and the key field (bits 31:16). Reading offset 0x00 returns the address, busy at bit ADDR_W, error at bit ADDR_W+1, bit ADDR_W+2 as zero, and the key at bits 31:16.
- R3: A write to offset 0x04 ORs the written address and key bits into the register. A write to offset 0x08 clears the address and key bits written as one.
- R4: A write to the data register at offset 0x20 is accepted when the key field holds 0x3E77, busy and error are low, and the addressed word is not locked. On acceptance, busy rises on the next cycle and the key field reads zero.
- R5: The controller reads the addressed fuse word and strobes only those bit positions that are one in the program data and zero in the fuse word. The fuse word afterwards equals its old value ORed with the data.
- R6: Busy stays high for exactly 2 + 32*STROBE_CYC cycles. Bit positions are visited from bit 0 upward, and each position occupies STROBE_CYC cycles.
- R7: During a burn the data register reads the masked data shifted right with zero fill, one place per finished bit position. Data writes made while busy are ignored.
- R8: Address field writes made during a burn do not change the word being programmed.
- R9: A request to a locked word causes no fuse read and no program strobe, leaves busy low, sets error and clears the key field.
- R10: While error is set, data writes are rejected even with a valid key. A plain write to offset 0x00 does not clear error. A write to offset 0x08 with bit ADDR_W+1 set clears it.
- R11: A data write while the key field does not hold 0x3E77 changes nothing: busy, error, the registers and the fuses are left as they were.
- R12: The key is consumed per request. A second data write after a finished burn, without a new key, starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_ofs | input | 6 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, valid the cycle after bus_rd_en |
| word_lock | input | 2**ADDR_W | One lock bit per fuse word |
| busy | output | 1 | Burn in progress |
| error | output | 1 | Sticky rejection flag |
| fuse_rd_en | output | 1 | Fuse word read strobe |
| fuse_addr | output | ADDR_W | Latched word address for read and program |
| fuse_rd_data | input | 32 | Fuse word contents, one cycle after fuse_rd_en |
| fuse_pgm_en | output | 1 | Program strobe for one fuse bit |
| fuse_pgm_bit | output | 5 | Bit position being programmed |

## Verification
The bench builds the block with ADDR_W of 8, which is the default layout with busy at bit 8 and error at bit 9. It sets STROBE_CYC to 3, so one full burn lasts 98 cycles. That short burn lets the bench run several complete burns and count the busy window exactly. It also lets the bench time a data-register read so that it lands after a known number of shifts. A pre-blown word in the fuse model exercises the masking, and a locked word exercises the error path and its clearing.

// File: rtl/otp_pkg.sv
package otp_pkg;
  localparam int WORD_W = 32;
  localparam int BIT_W  = $clog2(WORD_W);
  localparam int OFS_W  = 6;

  localparam logic [15:0] UNLOCK_KEY = 16'h3E77;

  localparam logic [OFS_W-1:0] OFS_CTRL = 6'h00;
  localparam logic [OFS_W-1:0] OFS_SET  = 6'h04;
  localparam logic [OFS_W-1:0] OFS_CLR  = 6'h08;
  localparam logic [OFS_W-1:0] OFS_DATA = 6'h20;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_READ,
    SEQ_MASK,
    SEQ_BURN
  } seq_state_e;
endpackage

// File: rtl/otp_ctrl_regs.sv
module otp_ctrl_regs
  import otp_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [OFS_W-1:0]  wr_ofs,
  input  logic [ADDR_W-1:0] wr_addr_bits,
  input  logic [15:0]       wr_key_bits,
  input  logic              wr_err_bit,
  input  logic              seq_busy,
  input  logic              lock_hit,
  output logic [ADDR_W-1:0] addr_q,
  output logic [15:0]       key_q,
  output logic              error_q,
  output logic              start
);
  logic data_wr, key_ok, attempt, lock_fail;

  always_comb begin
    data_wr   = wr_en && (wr_ofs == OFS_DATA);
    key_ok    = (key_q == UNLOCK_KEY);
    attempt   = data_wr && key_ok && !seq_busy && !error_q;
    start     = attempt && !lock_hit;
    lock_fail = attempt && lock_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      key_q   <= '0;
      error_q <= 1'b0;
    end else begin
      if (wr_en) begin
        unique case (wr_ofs)
          OFS_CTRL: begin
            addr_q <= wr_addr_bits;
            key_q  <= wr_key_bits;
          end
          OFS_SET: begin
            addr_q <= addr_q | wr_addr_bits;
            key_q  <= key_q | wr_key_bits;
          end
          OFS_CLR: begin
            addr_q <= addr_q & ~wr_addr_bits;
            key_q  <= key_q & ~wr_key_bits;
            if (wr_err_bit) error_q <= 1'b0;
          end
          default: ;
        endcase
      end
      if (start) key_q <= '0;
      if (lock_fail) begin
        key_q   <= '0;
        error_q <= 1'b1;
      end
    end
  end

  assert_key_oneshot_R4: assert property (@(posedge clk) disable iff (rst)
    start |=> (key_q == '0))
    else $error("key survived an accepted request");

  assert_lock_sets_error_R9: assert property (@(posedge clk) disable iff (rst)
    lock_fail |=> (error_q && !seq_busy))
    else $error("locked request did not flag error");

  assert_error_clear_path_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(error_q) |-> $past(wr_en && (wr_ofs == OFS_CLR) && wr_err_bit))
    else $error("error cleared without clear alias");

  assert_nokey_ignored_R11: assert property (@(posedge clk) disable iff (rst)
    (data_wr && !key_ok) |=> ($stable(key_q) && $stable(error_q) && $stable(addr_q)))
    else $error("keyless data write changed state");
endmodule

// File: rtl/otp_burn_seq.sv
module otp_burn_seq
  import otp_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int STROBE_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [WORD_W-1:0] start_data,
  input  logic [WORD_W-1:0] fuse_rd_data,
  output logic              busy,
  output logic [WORD_W-1:0] data_q,
  output logic [ADDR_W-1:0] lat_addr,
  output logic              fuse_rd_en,
  output logic              pgm_en,
  output logic [BIT_W-1:0]  pgm_bit
);
  localparam int CNT_W = (STROBE_CYC > 1) ? $clog2(STROBE_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STROBE_CYC - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(WORD_W - 1);

  seq_state_e       state;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SEQ_IDLE;
      data_q     <= '0;
      lat_addr   <= '0;
      fuse_rd_en <= 1'b0;
      pgm_bit    <= '0;
      cnt        <= '0;
    end else begin
      unique case (state)
        SEQ_IDLE: if (start) begin
          data_q     <= start_data;
          lat_addr   <= start_addr;
          fuse_rd_en <= 1'b1;
          state      <= SEQ_READ;
        end
        SEQ_READ: begin
          fuse_rd_en <= 1'b0;
          state      <= SEQ_MASK;
        end
        SEQ_MASK: begin
          data_q  <= data_q & ~fuse_rd_data;
          pgm_bit <= '0;
          cnt     <= '0;
          state   <= SEQ_BURN;
        end
        SEQ_BURN: begin
          if (cnt == CNT_LAST) begin
            cnt    <= '0;
            data_q <= data_q >> 1;
            if (pgm_bit == BIT_LAST) state <= SEQ_IDLE;
            else pgm_bit <= pgm_bit + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  always_comb begin
    busy   = (state != SEQ_IDLE);
    pgm_en = (state == SEQ_BURN) && data_q[0];
  end

  assert_addr_latched_R8: assert property (@(posedge clk) disable iff (rst)
    ((state != SEQ_IDLE) && ($past(state) != SEQ_IDLE)) |-> $stable(lat_addr))
    else $error("latched address moved during burn");

  assert_read_then_mask_R5: assert property (@(posedge clk) disable iff (rst)
    (state == SEQ_READ) |=> (state == SEQ_MASK && !fuse_rd_en))
    else $error("read phase out of order");

  assert_start_reads_R6: assert property (@(posedge clk) disable iff (rst)
    (state == SEQ_IDLE && start) |=> (state == SEQ_READ && fuse_rd_en))
    else $error("accepted request did not begin with fuse read");

  assert_shift_boundary_R7: assert property (@(posedge clk) disable iff (rst)
    ((state == SEQ_BURN) && ($past(state) == SEQ_BURN) && ($past(cnt) != CNT_LAST))
      |-> $stable(data_q))
    else $error("data shifted inside a strobe interval");
endmodule

// File: rtl/otp_read_mux.sv
module otp_read_mux
  import otp_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [OFS_W-1:0]  rd_ofs,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [15:0]       key_q,
  input  logic              busy,
  input  logic              error_q,
  input  logic [WORD_W-1:0] data_q,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] ctrl_view;

  always_comb begin
    ctrl_view               = '0;
    ctrl_view[ADDR_W-1:0]   = addr_q;
    ctrl_view[ADDR_W]       = busy;
    ctrl_view[ADDR_W+1]     = error_q;
    ctrl_view[WORD_W-1:16]  = key_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      unique case (rd_ofs)
        OFS_CTRL, OFS_SET, OFS_CLR: rdata <= ctrl_view;
        OFS_DATA:                   rdata <= data_q;
        default:                    rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/otp_fuse_prog.sv
module otp_fuse_prog
  import otp_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int STROBE_CYC = 4,
  localparam int NUM_WORDS = 2 ** ADDR_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr_en,
  input  logic                 bus_rd_en,
  input  logic [OFS_W-1:0]     bus_ofs,
  input  logic [WORD_W-1:0]    bus_wdata,
  output logic [WORD_W-1:0]    bus_rdata,
  input  logic [NUM_WORDS-1:0] word_lock,
  output logic                 busy,
  output logic                 error,
  output logic                 fuse_rd_en,
  output logic [ADDR_W-1:0]    fuse_addr,
  input  logic [WORD_W-1:0]    fuse_rd_data,
  output logic                 fuse_pgm_en,
  output logic [BIT_W-1:0]     fuse_pgm_bit
);
  logic [ADDR_W-1:0] addr_q;
  logic [15:0]       key_q;
  logic              start, lock_hit;
  logic [WORD_W-1:0] data_q;

  assign lock_hit = word_lock[addr_q];

  otp_ctrl_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (bus_wr_en),
    .wr_ofs      (bus_ofs),
    .wr_addr_bits(bus_wdata[ADDR_W-1:0]),
    .wr_key_bits (bus_wdata[WORD_W-1:16]),
    .wr_err_bit  (bus_wdata[ADDR_W+1]),
    .seq_busy    (busy),
    .lock_hit    (lock_hit),
    .addr_q      (addr_q),
    .key_q       (key_q),
    .error_q     (error),
    .start       (start)
  );

  otp_burn_seq #(.ADDR_W(ADDR_W), .STROBE_CYC(STROBE_CYC)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .start_addr  (addr_q),
    .start_data  (bus_wdata),
    .fuse_rd_data(fuse_rd_data),
    .busy        (busy),
    .data_q      (data_q),
    .lat_addr    (fuse_addr),
    .fuse_rd_en  (fuse_rd_en),
    .pgm_en      (fuse_pgm_en),
    .pgm_bit     (fuse_pgm_bit)
  );

  otp_read_mux #(.ADDR_W(ADDR_W)) u_rmux (
    .clk    (clk),
    .rst    (rst),
    .rd_en  (bus_rd_en),
    .rd_ofs (bus_ofs),
    .addr_q (addr_q),
    .key_q  (key_q),
    .busy   (busy),
    .error_q(error),
    .data_q (data_q),
    .rdata  (bus_rdata)
  );

  assert_no_access_when_idle_R1: assert property (@(posedge clk) disable iff (rst)
    (!busy) |-> (!fuse_pgm_en && !fuse_rd_en))
    else $error("fuse activity while idle");
endmodule

// File: tb/otp_fuse_prog_tb_top.sv
module otp_fuse_prog_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 8;
  localparam int STROBE     = 3;
  localparam int NW         = 2 ** ADDR_W;
  localparam logic [15:0] KEY = 16'h3E77;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr_en = 1'b0, bus_rd_en = 1'b0;
  logic [5:0]    bus_ofs = '0;
  logic [31:0]   bus_wdata = '0, bus_rdata;
  logic [NW-1:0] word_lock = '0;
  logic          busy, error, fuse_rd_en, fuse_pgm_en;
  logic [ADDR_W-1:0] fuse_addr;
  logic [31:0]   fuse_rd_data;
  logic [4:0]    fuse_pgm_bit;

  always #(CLK_PERIOD/2) clk = ~clk;

  otp_fuse_prog #(.ADDR_W(ADDR_W), .STROBE_CYC(STROBE)) dut_i (
    .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_ofs(bus_ofs), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .word_lock(word_lock), .busy(busy), .error(error),
    .fuse_rd_en(fuse_rd_en), .fuse_addr(fuse_addr), .fuse_rd_data(fuse_rd_data),
    .fuse_pgm_en(fuse_pgm_en), .fuse_pgm_bit(fuse_pgm_bit)
  );

  // Behavioural fuse array
  logic [31:0] fuse_mem [NW];
  int rd_cnt = 0, pgm_cnt = 0;
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NW; i++) fuse_mem[i] <= '0;
      fuse_mem[5]  <= 32'h0000_00F0;
      fuse_rd_data <= '0;
    end else begin
      if (fuse_rd_en) begin
        fuse_rd_data <= fuse_mem[fuse_addr];
        rd_cnt <= rd_cnt + 1;
      end
      if (fuse_pgm_en) begin
        fuse_mem[fuse_addr][fuse_pgm_bit] <= 1'b1;
        pgm_cnt <= pgm_cnt + 1;
      end
    end
  end

  int checks = 0, failures = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Scoreboard of expected program strobe cycles: {addr, bit}
  logic [ADDR_W+4:0] exp_q[$];

  always @(negedge clk) begin
    if (!rst && fuse_pgm_en) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5 unexpected strobe", 32'({fuse_addr, fuse_pgm_bit}), 32'hFFFF_FFFF);
      end else begin
        logic [ADDR_W+4:0] e;
        e = exp_q.pop_front();
        check({fuse_addr, fuse_pgm_bit} == e, "R5/R6/R8 strobe order",
              32'({fuse_addr, fuse_pgm_bit}), 32'(e));
      end
    end
  end

  task automatic bus_write(input logic [5:0] o, input logic [31:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_ofs = o; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] o, output logic [31:0] v);
    @(negedge clk);
    bus_rd_en = 1'b1; bus_ofs = o;
    @(negedge clk);
    bus_rd_en = 1'b0;
    v = bus_rdata;
  endtask

  task automatic push_expect(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    logic [31:0] need;
    need = d & ~fuse_mem[a];
    for (int b = 0; b < 32; b++)
      if (need[b])
        for (int s = 0; s < STROBE; s++) exp_q.push_back({a, 5'(b)});
  endtask

  task automatic burn_word(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    push_expect(a, d);
    bus_write(6'h00, {KEY, 8'h00, a});
    bus_write(6'h20, d);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  function automatic bit finish_now();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    return 1'b1;
  endfunction

  initial begin
    repeat (2000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    void'(finish_now());
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n, p0, r0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    word_lock[7] = 1'b1;

    // R1 reset state
    check(!busy && !error, "R1 flags", {30'd0, busy, error}, 32'd0);
    bus_read(6'h00, v); check(v == 32'd0, "R1 ctrl", v, 32'd0);
    bus_read(6'h20, v); check(v == 32'd0, "R1 data", v, 32'd0);

    // R11 keyless data write
    bus_write(6'h20, 32'hFFFF_FFFF);
    repeat (3) @(negedge clk);
    check(!busy && rd_cnt == 0, "R11 no start", 32'(rd_cnt), 32'd0);
    bus_read(6'h20, v); check(v == 32'd0, "R11 data untouched", v, 32'd0);
    bus_read(6'h00, v); check(v == 32'd0, "R11 ctrl untouched", v, 32'd0);

    // R2 layout, R3 aliases
    bus_write(6'h00, 32'h1234_0055);
    bus_read(6'h00, v); check(v == 32'h1234_0055, "R2 ctrl write", v, 32'h1234_0055);
    bus_write(6'h04, 32'h0000_000A);
    bus_read(6'h00, v); check(v == 32'h1234_005F, "R3 set alias", v, 32'h1234_005F);
    bus_write(6'h08, 32'h1200_0041);
    bus_read(6'h00, v); check(v == 32'h0034_001E, "R3 clr alias", v, 32'h0034_001E);
    bus_write(6'h08, 32'hFFFF_FFFF);

    // Burn A: masking, busy window
    p0 = pgm_cnt;
    burn_word(8'd5, 32'h8000_01FF);
    check(busy, "R4 busy raised", {31'd0, busy}, 32'd1);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    check(n == 2 + 32*STROBE, "R6 busy length", 32'(n), 32'(2 + 32*STROBE));
    @(negedge clk);
    check(fuse_mem[5] == 32'h8000_01FF, "R5 fuse result", fuse_mem[5], 32'h8000_01FF);
    check(pgm_cnt - p0 == 6*STROBE, "R5 strobe count", 32'(pgm_cnt - p0), 32'(6*STROBE));

    // Burn B: key consumed
    burn_word(8'd9, 32'hA5A5_0003);
    bus_read(6'h00, v); check(v == 32'h0000_0109, "R4 key cleared", v, 32'h0000_0109);
    wait_idle();
    @(negedge clk);
    check(fuse_mem[9] == 32'hA5A5_0003, "R5 fuse B", fuse_mem[9], 32'hA5A5_0003);

    // Burn C: shift readback, ignored data write, latched address
    burn_word(8'd12, 32'h0000_FF00);
    repeat (2 + 4*STROBE) @(negedge clk);
    bus_read(6'h20, v); check(v == 32'h0000_0FF0, "R7 shifted data", v, 32'h0000_0FF0);
    bus_write(6'h00, {KEY, 16'h0030});
    bus_write(6'h20, 32'hFFFF_FFFF);
    wait_idle();
    @(negedge clk);
    check(fuse_mem[12] == 32'h0000_FF00, "R7 busy write ignored", fuse_mem[12], 32'h0000_FF00);
    check(fuse_mem[48] == 32'd0, "R8 new address untouched", fuse_mem[48], 32'd0);
    bus_write(6'h08, 32'hFFFF_FFFF);

    // R12 key needed per request
    burn_word(8'd20, 32'h0000_0001);
    wait_idle();
    r0 = rd_cnt;
    bus_write(6'h20, 32'h0000_0002);
    repeat (3) @(negedge clk);
    check(!busy && rd_cnt == r0, "R12 no restart", 32'(rd_cnt - r0), 32'd0);
    check(fuse_mem[20] == 32'h1, "R12 fuse", fuse_mem[20], 32'h1);

    // R9 locked word
    r0 = rd_cnt; p0 = pgm_cnt;
    bus_write(6'h00, {KEY, 16'h0007});
    bus_write(6'h20, 32'h0000_00FF);
    check(!busy && error, "R9 flags", {30'd0, busy, error}, 32'd1);
    repeat (3) @(negedge clk);
    check(rd_cnt == r0 && pgm_cnt == p0, "R9 no fuse access", 32'(rd_cnt - r0), 32'd0);
    bus_read(6'h00, v); check(v == 32'h0000_0207, "R9 ctrl view", v, 32'h0000_0207);

    // R10 error gating and clearing
    bus_write(6'h00, {KEY, 16'h0008});
    bus_write(6'h20, 32'h0000_0001);
    repeat (3) @(negedge clk);
    check(!busy && fuse_mem[8] == 0, "R10 rejected while error", fuse_mem[8], 32'd0);
    bus_write(6'h00, 32'h0000_0008);
    check(error, "R10 direct write keeps error", {31'd0, error}, 32'd1);
    bus_write(6'h08, 32'h0000_0200);
    check(!error, "R10 clr alias", {31'd0, error}, 32'd0);
    burn_word(8'd8, 32'h0000_0001);
    wait_idle();
    @(negedge clk);
    check(fuse_mem[8] == 32'h1, "R10 burn after clear", fuse_mem[8], 32'h1);

    check(exp_q.size() == 0, "R5 scoreboard drained", 32'(exp_q.size()), 32'd0);
    void'(finish_now());
    $finish;
  end
endmodule